// File: doc/BRIEF.md
# Byte-Wide GPIO Port with Rising-Edge Interrupts

An eight-pin general-purpose I/O port that sits on a small register bus. Software sets each pin's direction and output level, reads back the pad levels through a two-flop synchroniser, and can arm a rising-edge interrupt per pin. Edge detection looks at the actual pad level, not the output register. An enabled pin that is driven as an output therefore raises its own interrupt when software writes it high, which gives a software interrupt without extra hardware.

Output bits can be changed in four ways:
- a whole-byte store;
- a toggle-by-write at the input address;
- separate set-mask and clear-mask addresses;
- a two-cycle single-bit command.

The single-bit command rebuilds the whole output byte from the synchronised pad levels it sampled, then forces the one chosen bit. Any pin whose pad level differs from its output register is rewritten to the pad level. Every other access completes in one cycle.

Top module: `gpio_edge_port`

## Requirements
- R1: After synchronous reset, pad_oe and pad_out are all zero, all interrupt flags are clear, irq is low and busy is low.
- R2: An accepted write at address 0 (direction, 1 = output) or address 1 (output value) replaces the whole byte, and the new value appears on pad_oe or pad_out in the cycle after the accepting edge. An output value written while the pin is an input is driven once the direction bit is set.
- R3: A read at address 2 returns the pad_in level delayed by the two-flop synchroniser, never the output register.
- R4: A write at address 2 inverts each output bit whose written bit is 1 and leaves the bits written 0 unchanged.
- R5: A write at address 3 sets the output bits selected by ones, and a write at address 4 clears them. The remaining bits keep their value.
- R6: A write at address 7 is a single-bit command: wdata[2:0] is the pin index and wdata[3] is the new level. In the accepting cycle it samples the synchronised pad byte. In the next cycle busy is high, bus_ready is low, and the output register is loaded with that sample with the chosen bit replaced.
- R7: A rising edge on a synchronised pad level, at a pin whose bit in the enable register (address 5) is 1, sets that pin's flag. This includes pins driven as outputs. A read at address 6 returns the flags.
- R8: Writing ones at address 6 clears those flags. If a clear and a new edge hit the same flag in one cycle, the flag stays set.
- R9: irq is high exactly when some flag is set and its enable bit is 1.
- R10: A read accepted on one edge presents its data on bus_rdata from that edge on. Bus accesses are accepted only while bus_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_ready | output | 1 | Access accepted this cycle when high |
| bus_rdata | output | 8 | Registered read data |
| busy | output | 1 | Second cycle of a single-bit command |
| pad_in | input | 8 | Pad levels |
| pad_out | output | 8 | Output data to pads |
| pad_oe | output | 8 | Output enables to pads |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets four behaviours:
- **Software interrupt from an output pin.** A design that detected edges on the input direction only, or on the output register instead of the pad, would leave irq low.
- **Pad-level rebuild in the single-bit command.** The command runs while an input pin's pad level differs from its output register bit. A design that started from the output register would leave that bit unchanged. A design that dropped the busy cycle would let a queued write slip in early.
- **Clear racing a new edge.** A flag clear is timed to land on the very edge where a new edge sets the same flag. Letting the clear win would lose that interrupt.
- **Toggle at the input address.** Writes mix ones and zeros, so a toggle that also touched the zero bits would show up.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [2:0] {
    A_DIR  = 3'd0,
    A_OUT  = 3'd1,
    A_IN   = 3'd2,
    A_SET  = 3'd3,
    A_CLR  = 3'd4,
    A_EN   = 3'd5,
    A_FLAG = 3'd6,
    A_BIT  = 3'd7
  } gpio_addr_e;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] s1, s2, s3;

  for (genvar i = 0; i < W; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        s1[i] <= 1'b0;
        s2[i] <= 1'b0;
        s3[i] <= 1'b0;
      end else begin
        s1[i] <= pad_in[i];
        s2[i] <= s1[i];
        s3[i] <= s2[i];
      end
    end
    assign rise[i] = s2[i] & ~s3[i];
  end

  assign lvl = s2;
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_pkg::*;
#(
  parameter int W  = 8,
  parameter int IW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  gpio_addr_e   addr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] out_q,
  output logic [W-1:0] en_q,
  output logic         busy
);
  logic [W-1:0]  snap;
  logic [IW-1:0] idx;
  logic          val;
  logic [W-1:0]  snap_mod;

  always_comb begin
    snap_mod      = snap;
    snap_mod[idx] = val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
      out_q <= '0;
      en_q  <= '0;
      busy  <= 1'b0;
      snap  <= '0;
      idx   <= '0;
      val   <= 1'b0;
    end else if (busy) begin
      out_q <= snap_mod;
      busy  <= 1'b0;
    end else if (wr) begin
      case (addr)
        A_DIR: dir_q <= wdata;
        A_OUT: out_q <= wdata;
        A_IN:  out_q <= out_q ^ wdata;
        A_SET: out_q <= out_q | wdata;
        A_CLR: out_q <= out_q & ~wdata;
        A_EN:  en_q  <= wdata;
        A_BIT: begin
          snap <= lvl;
          idx  <= wdata[IW-1:0];
          val  <= wdata[IW];
          busy <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R6: the command occupies exactly one extra cycle
  assert_busy_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy);
  assert_busy_from_cmd_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wr && addr == A_BIT));
  // R5: set and clear addresses touch only the selected bits
  assert_set_bits_R5: assert property (@(posedge clk) disable iff (rst)
    (wr && !busy && addr == A_SET) |=> ((out_q & $past(wdata)) == $past(wdata)
      && (out_q & ~$past(wdata)) == ($past(out_q) & ~$past(wdata))));
  assert_clr_bits_R5: assert property (@(posedge clk) disable iff (rst)
    (wr && !busy && addr == A_CLR) |=> ((out_q & $past(wdata)) == '0
      && (out_q & ~$past(wdata)) == ($past(out_q) & ~$past(wdata))));
endmodule

// File: rtl/gpio_irq_flags.sv
module gpio_irq_flags #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] rise,
  input  logic [W-1:0] en,
  input  logic [W-1:0] clr,
  output logic [W-1:0] flags,
  output logic         irq
);
  logic [W-1:0] hit;
  assign hit = rise & en;

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (flags & ~clr) | hit;
  end

  assign irq = |(flags & en);

  // R8: a flag drops only through an explicit clear
  assert_flag_hold_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags & $past(flags & ~clr)) == $past(flags & ~clr)));
  // R8 / R7: an enabled edge always lands, even against a clear
  assert_edge_wins_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags & $past(hit)) == $past(hit)));
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_pkg::*;
#(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic          bus_ready,
  output logic [W-1:0]  bus_rdata,
  output logic          busy,
  input  logic [W-1:0]  pad_in,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_oe,
  output logic          irq
);
  logic         accept, wr, rd;
  logic [W-1:0] lvl, rise, dir_q, out_q, en_q, flags, clr;
  gpio_addr_e   addr;

  assign addr      = gpio_addr_e'(bus_addr);
  assign bus_ready = ~busy;
  assign accept    = bus_valid & ~busy;
  assign wr        = accept & bus_write;
  assign rd        = accept & ~bus_write;
  assign clr       = (wr && addr == A_FLAG) ? bus_wdata : '0;

  gpio_pin_sync #(.W(W)) u_sync (
    .clk(clk), .rst(rst), .pad_in(pad_in), .lvl(lvl), .rise(rise)
  );

  gpio_port_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .wr(wr), .addr(addr), .wdata(bus_wdata),
    .lvl(lvl), .dir_q(dir_q), .out_q(out_q), .en_q(en_q), .busy(busy)
  );

  gpio_irq_flags #(.W(W)) u_irq (
    .clk(clk), .rst(rst), .rise(rise), .en(en_q), .clr(clr),
    .flags(flags), .irq(irq)
  );

  assign pad_out = out_q;
  assign pad_oe  = dir_q;

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (rd) begin
      case (addr)
        A_DIR:   bus_rdata <= dir_q;
        A_OUT:   bus_rdata <= out_q;
        A_IN:    bus_rdata <= lvl;
        A_EN:    bus_rdata <= en_q;
        A_FLAG:  bus_rdata <= flags;
        default: bus_rdata <= '0;
      endcase
    end
  end

  // R2: a direction store reaches the pads on the next cycle
  assert_dir_store_R2: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == A_DIR) |=> (pad_oe == $past(bus_wdata)));
endmodule

// File: tb/gpio_edge_port_bench.sv
module gpio_edge_port_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_valid = 1'b0, bus_write = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, ext = '0;
  logic       bus_ready, busy, irq;
  logic [7:0] bus_rdata, pad_out, pad_oe, pad_in;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;
  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

  gpio_edge_port u_gpio_edge_port (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .bus_rdata(bus_rdata), .busy(busy), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [7:0] m_dir, m_out, m_en, m_flag, m_s1, m_s2, m_s3, m_snap, m_rd;
  logic [7:0] pad_v, rise_v, clr_v;
  logic [2:0] m_idx;
  logic       m_val, m_busy;

  always @(posedge clk) begin
    if (rst) begin
      m_dir = 0; m_out = 0; m_en = 0; m_flag = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
      m_snap = 0; m_rd = 0; m_idx = 0; m_val = 0; m_busy = 0;
    end else begin
      pad_v  = (m_dir & m_out) | (~m_dir & ext);
      rise_v = m_s2 & ~m_s3 & m_en;
      clr_v  = 0;
      if (m_busy) begin
        m_out = m_snap;
        m_out[m_idx] = m_val;
        m_busy = 0;
      end else if (bus_valid && bus_write) begin
        case (bus_addr)
          0: m_dir = bus_wdata;
          1: m_out = bus_wdata;
          2: m_out = m_out ^ bus_wdata;
          3: m_out = m_out | bus_wdata;
          4: m_out = m_out & ~bus_wdata;
          5: m_en  = bus_wdata;
          6: clr_v = bus_wdata;
          default: begin
            m_snap = m_s2; m_idx = bus_wdata[2:0]; m_val = bus_wdata[3]; m_busy = 1;
          end
        endcase
      end else if (bus_valid) begin
        case (bus_addr)
          0: m_rd = m_dir;
          1: m_rd = m_out;
          2: m_rd = m_s2;
          5: m_rd = m_en;
          6: m_rd = m_flag;
          default: m_rd = 0;
        endcase
      end
      m_flag = (m_flag & ~clr_v) | rise_v;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = pad_v;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R2 pad_out model", pad_out, m_out);
      chk("R2 pad_oe model", pad_oe, m_dir);
      chk("R9 irq model", {7'd0, irq}, {7'd0, |(m_flag & m_en)});
      chk("R6 busy model", {7'd0, busy}, {7'd0, m_busy});
      chk("R10 ready model", {7'd0, bus_ready}, {7'd0, !m_busy});
      chk("R10 rdata model", bus_rdata, m_rd);
    end
  end

  task automatic acc(input logic w, input logic [2:0] a, input logic [7:0] d);
    bus_valid = 1; bus_write = w; bus_addr = a; bus_wdata = d;
    while (!bus_ready) @(negedge clk);
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rdchk(input logic [2:0] a, input logic [7:0] exp, input string tag);
    acc(0, a, 8'h00);
    chk(tag, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst = 0;
    @(negedge clk);
    chk("R1 reset pad_oe", pad_oe, 8'h00);
    chk("R1 reset pad_out", pad_out, 8'h00);
    chk("R1 reset irq", {7'd0, irq}, 8'h00);
    chk("R1 reset busy", {7'd0, busy}, 8'h00);
    rdchk(3'd6, 8'h00, "R1 reset flags");

    acc(1, 3'd1, 8'hA5);
    chk("R2 out stored while input", pad_out, 8'hA5);
    chk("R2 still input", pad_oe, 8'h00);
    acc(1, 3'd0, 8'h0F);
    chk("R2 direction to output", pad_oe, 8'h0F);
    rdchk(3'd0, 8'h0F, "R10 read direction");

    ext = 8'h3C;
    idle(3);
    rdchk(3'd2, 8'h35, "R3 input reads pad level");

    acc(1, 3'd2, 8'h11);
    chk("R4 toggle via input address", pad_out, 8'hB4);
    acc(1, 3'd3, 8'h03);
    chk("R5 set mask", pad_out, 8'hB7);
    acc(1, 3'd4, 8'h84);
    chk("R5 clear mask", pad_out, 8'h33);

    ext = 8'hC0;
    idle(3);
    acc(1, 3'd7, 8'h0A);
    chk("R6 busy in second cycle", {7'd0, busy}, 8'h01);
    chk("R6 not yet written", pad_out, 8'h33);
    @(negedge clk);
    chk("R6 rebuilt from pad levels", pad_out, 8'hC7);
    acc(1, 3'd7, 8'h03);
    acc(1, 3'd3, 8'h10);
    chk("R6 queued write after command", pad_out, 8'hD3);

    acc(1, 3'd4, 8'h01);
    idle(4);
    acc(1, 3'd6, 8'hFF);
    acc(1, 3'd5, 8'h01);
    acc(1, 3'd3, 8'h01);
    idle(4);
    chk("R7 software interrupt from output", {7'd0, irq}, 8'h01);
    rdchk(3'd6, 8'h01, "R7 flag from output pin");
    ext = 8'h80;
    idle(2);
    ext = 8'hC0;
    idle(4);
    rdchk(3'd6, 8'h01, "R7 disabled pin no flag");
    acc(1, 3'd5, 8'h00);
    chk("R9 masked irq", {7'd0, irq}, 8'h00);
    acc(1, 3'd5, 8'h01);
    chk("R9 unmasked irq", {7'd0, irq}, 8'h01);
    acc(1, 3'd6, 8'h01);
    chk("R8 write-one clear", {7'd0, irq}, 8'h00);

    acc(1, 3'd4, 8'h01);
    idle(4);
    acc(1, 3'd3, 8'h01);
    idle(2);
    acc(1, 3'd6, 8'h01);
    rdchk(3'd6, 8'h01, "R8 set wins over clear");

    idle(3);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule